// File: doc/BRIEF.md
# Bidirectional Recirculating Shift Register

A 32-stage serial shift register that moves its contents one stage per rising clock edge, either toward the high end (right) or toward the low end (left). A direction input picks the way. A wrap-select input picks the bit that fills the vacated end stage: it is either the serial input for that direction or the bit leaving the opposite end, which makes the register a rotating loop. A freeze input stops all movement.

The stages are numbered 1 to 32. Two serial outputs show the end stages: one shows stage 1 and the other shows stage 32. Each output is taken by a flop clocked on the falling clock edge, so it changes half a clock period after the rising edge that moved the data. Controls are sampled at the rising edge. They may change only while the clock is low. A synchronous active-high reset clears every stage and both output flops.

Top module: `bidir_recirc_shreg`

## Requirements
- R1: The register holds 32 stages. A single 1 entered into stage 1 by a right shift shows on `end_hi_q` after exactly 32 right shifts, and not before.
- R2: With `dir_left`=0, `feed_ext`=1 and `freeze`=0, a rising edge loads `ser_in_r` into stage 1 and moves stage k into stage k+1 for k = 1..31.
- R3: With `dir_left`=1, `feed_ext`=1 and `freeze`=0, a rising edge loads `ser_in_l` into stage 32 and moves stage k into stage k-1 for k = 2..32.
- R4: With `freeze`=1, a rising edge leaves all stages unchanged, whatever the other inputs are.
- R5: With `dir_left`=0, `feed_ext`=0 and `freeze`=0, stage 32 wraps into stage 1 during the right shift. 32 such shifts restore the original contents.
- R6: With `dir_left`=1, `feed_ext`=0 and `freeze`=0, stage 1 wraps into stage 32 during the left shift. 32 such shifts restore the original contents.
- R7: `end_lo_q` shows stage 1 and `end_hi_q` shows stage 32. Each output takes the new value at the falling edge after the shift and still shows the old value between the rising edge and that falling edge.
- R8: `dir_left`, `feed_ext` and `freeze` stay stable while the clock is high. A simulation check reports any value at the falling edge that differs from the value sampled at the preceding rising edge.
- R9: While `rst`=1, the rising edges clear all stages to 0 and the falling edges clear both outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. The stages shift on the rising edge; the outputs are re-timed on the falling edge |
| rst | input | 1 | Synchronous active-high reset |
| ser_in_r | input | 1 | Serial input to stage 1 during an external right shift |
| ser_in_l | input | 1 | Serial input to stage 32 during an external left shift |
| dir_left | input | 1 | 0 shifts toward stage 32; 1 shifts toward stage 1 |
| feed_ext | input | 1 | 1 takes the serial input; 0 wraps the opposite end stage |
| freeze | input | 1 | 1 holds all stages |
| end_lo_q | output | 1 | Stage 1, re-timed on the falling edge |
| end_hi_q | output | 1 | Stage 32, re-timed on the falling edge |

## Verification
The assertions assume that the three controls change only during the low phase of the clock. They also assume that reset is held from time zero for at least one full clock period, so that both edge domains start from zero. The bench drives every input one nanosecond after a falling edge and checks that the clock is low at that moment. A reference model predicts both outputs after each shift. The bench compares them after the next falling edge, and it also checks just after the rising edge that the old values are still present.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
  typedef enum logic [1:0] {
    MV_HOLD  = 2'd0,
    MV_RIGHT = 2'd1,
    MV_LEFT  = 2'd2
  } move_e;
endpackage

// File: rtl/shreg_ctrl_dec.sv
module shreg_ctrl_dec
  import shreg_pkg::*;
(
  input  logic  dir_left,
  input  logic  freeze,
  output move_e move
);
  always_comb begin
    if (freeze)        move = MV_HOLD;
    else if (dir_left) move = MV_LEFT;
    else               move = MV_RIGHT;
  end
endmodule

// File: rtl/shreg_stages.sv
module shreg_stages
  import shreg_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  move_e            move,
  input  logic             feed_ext,
  input  logic             ser_in_r,
  input  logic             ser_in_l,
  output logic [DEPTH-1:0] q
);
  localparam int TOP = DEPTH - 1;

  logic fill_lo;
  logic fill_hi;
  logic [DEPTH-1:0] nxt;

  assign fill_lo = feed_ext ? ser_in_r : q[TOP];
  assign fill_hi = feed_ext ? ser_in_l : q[0];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic from_below;
    logic from_above;
    if (i == 0) begin : g_lo
      assign from_below = fill_lo;
    end else begin : g_mid_lo
      assign from_below = q[i-1];
    end
    if (i == TOP) begin : g_hi
      assign from_above = fill_hi;
    end else begin : g_mid_hi
      assign from_above = q[i+1];
    end
    always_comb begin
      unique case (move)
        MV_RIGHT: nxt[i] = from_below;
        MV_LEFT:  nxt[i] = from_above;
        default:  nxt[i] = q[i];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    move == MV_HOLD |=> $stable(q));

  p_right_ext_r2: assert property (@(posedge clk) disable iff (rst)
    (move == MV_RIGHT && feed_ext) |=>
      (q[0] == $past(ser_in_r) && q[TOP:1] == $past(q[TOP-1:0])));

  p_left_ext_r3: assert property (@(posedge clk) disable iff (rst)
    (move == MV_LEFT && feed_ext) |=>
      (q[TOP] == $past(ser_in_l) && q[TOP-1:0] == $past(q[TOP:1])));

  p_wrap_right_r5: assert property (@(posedge clk) disable iff (rst)
    (move == MV_RIGHT && !feed_ext) |=> q == $past({q[TOP-1:0], q[TOP]}));

  p_wrap_left_r6: assert property (@(posedge clk) disable iff (rst)
    (move == MV_LEFT && !feed_ext) |=> q == $past({q[0], q[TOP:1]}));
endmodule

// File: rtl/shreg_edge_out.sv
module shreg_edge_out (
  input  logic clk,
  input  logic rst,
  input  logic lo_stage,
  input  logic hi_stage,
  output logic lo_q,
  output logic hi_q
);
  always_ff @(negedge clk) begin
    if (rst) begin
      lo_q <= 1'b0;
      hi_q <= 1'b0;
    end else begin
      lo_q <= lo_stage;
      hi_q <= hi_stage;
    end
  end

  // R7: at each rising edge, before the shift, the outputs match the end stages
  p_retime_r7: assert property (@(posedge clk) disable iff (rst)
    (lo_q == lo_stage && hi_q == hi_stage));
endmodule

// File: rtl/bidir_recirc_shreg.sv
module bidir_recirc_shreg
  import shreg_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic ser_in_r,
  input  logic ser_in_l,
  input  logic dir_left,
  input  logic feed_ext,
  input  logic freeze,
  output logic end_lo_q,
  output logic end_hi_q
);
  localparam int TOP = DEPTH - 1;

  move_e            move;
  logic [DEPTH-1:0] stages;

  shreg_ctrl_dec u_dec (
    .dir_left (dir_left),
    .freeze   (freeze),
    .move     (move)
  );

  shreg_stages #(.DEPTH(DEPTH)) u_stages (
    .clk      (clk),
    .rst      (rst),
    .move     (move),
    .feed_ext (feed_ext),
    .ser_in_r (ser_in_r),
    .ser_in_l (ser_in_l),
    .q        (stages)
  );

  shreg_edge_out u_out (
    .clk      (clk),
    .rst      (rst),
    .lo_stage (stages[0]),
    .hi_stage (stages[TOP]),
    .lo_q     (end_lo_q),
    .hi_q     (end_hi_q)
  );

  // R8: capture the controls at the rising edge and compare them at the falling edge
  logic [2:0] ctl_rise;
  logic       ctl_seen;
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_rise <= '0;
      ctl_seen <= 1'b0;
    end else begin
      ctl_rise <= {dir_left, feed_ext, freeze};
      ctl_seen <= 1'b1;
    end
  end

  p_ctrl_stable_r8: assert property (@(negedge clk) disable iff (rst)
    ctl_seen |-> ({dir_left, feed_ext, freeze} == ctl_rise));

  // R9: after a reset cycle the stages are clear
  p_reset_clear_r9: assert property (@(posedge clk)
    $past(rst) |-> stages == '0);
endmodule

// File: tb/bidir_recirc_shreg_tb_top.sv
module bidir_recirc_shreg_tb_top;
  localparam int N = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_in_r = 1'b0, ser_in_l = 1'b0;
  logic dir_left = 1'b0, feed_ext = 1'b1, freeze = 1'b0;
  logic end_lo_q, end_hi_q;

  always #5 clk = ~clk;

  bidir_recirc_shreg #(.DEPTH(N)) dut_i (
    .clk(clk), .rst(rst), .ser_in_r(ser_in_r), .ser_in_l(ser_in_l),
    .dir_left(dir_left), .feed_ext(feed_ext), .freeze(freeze),
    .end_lo_q(end_lo_q), .end_hi_q(end_hi_q)
  );

  typedef struct {
    logic  lo;
    logic  hi;
    string tag;
  } exp_t;

  exp_t        sb[$];
  logic [N-1:0] model = '0;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  task automatic check(bit ok, string tag, logic [1:0] act, logic [1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: outputs {lo,hi} actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: one rising edge with the given controls; pushes the expected outputs
  task automatic step(bit dl, bit fe, bit fz, bit sr, bit sl, string tag);
    logic old_lo, old_hi;
    @(negedge clk);
    #1;
    check(clk == 1'b0, "R8", {clk, 1'b0}, 2'b00);  // R8: controls move only in the low phase
    dir_left = dl; feed_ext = fe; freeze = fz; ser_in_r = sr; ser_in_l = sl;
    old_lo = model[0];
    old_hi = model[N-1];
    if (!fz) begin
      if (!dl) model = {model[N-2:0], fe ? sr : model[N-1]};
      else     model = {fe ? sl : model[0], model[N-1:1]};
    end
    @(posedge clk);
    #2;
    // R7: half a cycle of lag, so the old end values are still present
    check(end_lo_q === old_lo && end_hi_q === old_hi, "R7",
          {end_lo_q, end_hi_q}, {old_lo, old_hi});
    sb.push_back('{lo: model[0], hi: model[N-1], tag: tag});
  endtask

  task automatic do_reset();
    @(negedge clk);
    #1 rst = 1'b1;
    repeat (2) @(negedge clk);
    #1 rst = 1'b0;
    model = '0;
    sb.delete();
    @(negedge clk);
    #2;
    check(end_lo_q === 1'b0 && end_hi_q === 1'b0, "R9",
          {end_lo_q, end_hi_q}, 2'b00);
  endtask

  // Monitor: pops one expectation after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(end_lo_q === e.lo && end_hi_q === e.hi, e.tag,
              {end_lo_q, end_hi_q}, {e.lo, e.hi});
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] pat;
    pat = 32'hA5C3_1F0E;
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    #2;
    check(end_lo_q === 1'b0 && end_hi_q === 1'b0, "R9",
          {end_lo_q, end_hi_q}, 2'b00);

    // R1: one 1 walks 32 stages right
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R1");
    for (int i = 0; i < N - 1; i++) step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R1");

    // R2: load a pattern from the right-shift serial input
    for (int i = 0; i < N; i++) step(1'b0, 1'b1, 1'b0, pat[i], ~pat[i], "R2");

    // R4: freeze under every control mix and changing serial data
    for (int i = 0; i < 8; i++) step(i[0], i[1], 1'b1, ~i[0], i[2], "R4");

    // R5: rotate right twice round the loop
    for (int i = 0; i < 2 * N; i++) step(1'b0, 1'b0, 1'b0, i[0], i[1], "R5");

    // R6: rotate left twice round the loop
    for (int i = 0; i < 2 * N; i++) step(1'b1, 1'b0, 1'b0, i[1], i[0], "R6");

    // R3: load from the left-shift serial input, past the full depth
    for (int i = 0; i < N + 8; i++) step(1'b1, 1'b1, 1'b0, ~pat[i % N], pat[(i * 7) % N], "R3");

    // R5, R6: alternating directions with wrap
    for (int i = 0; i < 10; i++) step(i[0], 1'b0, 1'b0, 1'b0, 1'b0, "R5");

    // R9: reset after data has been loaded
    do_reset();
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R9");

    repeat (3) @(negedge clk);
    #3;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule